// File: doc/BRIEF.md
# Core Voltage-Frequency Transition Sequencer

This block moves a core from its present operating point, a core clock ratio plus a voltage identification (VID) code, to a requested one. The order of the two changes follows the direction of the move. When the new ratio is higher, the voltage must be raised before the faster clock is applied. When the new ratio is lower or equal, the clock is slowed first and the voltage is lowered afterwards. The voltage is never jumped. It walks one VID code (12.5 mV) at a time, and each step is followed by a programmable settle interval that stands in for the regulator slewing. Only the internal core ratio is changed; the bus clock is not touched by this block.

Two sources start a sequence. Software writes a target point, whose ratio is clamped to a maximum-ratio input. A power manager requests entry into, or exit from, a deep idle point. On entry the present point is saved and the core drops to a fixed low point. On exit the saved point is restored. Requests that arrive while a sequence runs are held and started when the engine is idle again. A one-cycle done pulse marks the end of every sequence.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `vf_sequencer`

## Requirements
- R1: During reset and after its release with no request, `core_ratio` equals RESET_RATIO (default 8), `core_vid` equals RESET_VID (default 40), and `busy` and `done` are 0. A larger VID code means a higher voltage.
- R2: When the target ratio is above the applied ratio, every VID change of the sequence happens before the ratio changes. The ratio and the VID never change on the same clock edge.
- R3: When the target ratio is at or below the applied ratio, the ratio changes before the first VID change of the sequence.
- R4: `core_vid` changes by exactly one code (12.5 mV) at a time. Two VID changes are at least `settle_cycles`+1 cycles apart. A sequence of N VID steps with a ratio change is busy for N*(settle_cycles+1)+2 cycles.
- R5: A written target ratio above `max_ratio`, as sampled in the write cycle, is replaced by `max_ratio`.
- R6: A `halt_enter` pulse saves the applied point and runs a sequence to LOW_RATIO (default 6) and LOW_VID (default 32). The ratio changes first, then the VID steps down.
- R7: A `halt_exit` pulse after an entry runs a sequence back to the saved point. The VID steps come first, then the ratio changes.
- R8: A target written while a sequence runs is held and applied after the running sequence completes. A later write before the start replaces an earlier held one. The ratio changes only while `busy` is 1.
- R9: While the core is in the deep idle point, written targets do not start a sequence. The last one is applied after the exit sequence completes.
- R10: `halt_enter` while already in (or entering) deep idle is ignored. `halt_exit` outside deep idle is ignored. The two pulses in the same cycle are both ignored.
- R11: A `halt_exit` arriving while an entry request is still held and not yet started cancels the entry. No sequence runs and the applied point stays unchanged.
- R12: `done` is a single-cycle pulse, raised once for each completed sequence, with `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe that writes a new target point |
| wr_ratio | input | RATIO_W | Target core clock ratio |
| wr_vid | input | VID_W | Target VID code |
| max_ratio | input | RATIO_W | Highest ratio a write may request |
| halt_enter | input | 1 | One-cycle request to drop to the deep idle point |
| halt_exit | input | 1 | One-cycle request to leave the deep idle point |
| settle_cycles | input | SETTLE_W | Wait in cycles after each VID step |
| core_ratio | output | RATIO_W | Applied core clock ratio |
| core_vid | output | VID_W | Applied VID code |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The two functions most likely to land in the same cycle are the request capture and the sequence engine. A write or an idle request can arrive while a sequence is stepping, or in the very cycle that sequence is started or finished. The bench provokes this by forking the write and idle pulses against a running sequence, at several offsets into it. It judges the result by the order and final values of the following sequences. Writes issued mid-sequence must produce exactly one extra sequence to the last written point. An exit issued before a pending entry starts must leave the point untouched and raise no further `busy`.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RATIO  = 3'd1,
    ST_VSTEP  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_FIN    = 3'd4
  } seq_state_e;

endpackage

// File: rtl/vfs_settle_timer.sv
module vfs_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] value,
  output logic                last
);

  logic [SETTLE_W-1:0] cnt_q, cnt_n;
  logic                cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_n  = value;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - SETTLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign last = (cnt_q == SETTLE_W'(1));

endmodule

// File: rtl/vfs_request_queue.sv
module vfs_request_queue #(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 7,
  parameter int LOW_RATIO = 6,
  parameter int LOW_VID   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic [VID_W-1:0]   wr_vid,
  input  logic [RATIO_W-1:0] max_ratio,
  input  logic               halt_enter,
  input  logic               halt_exit,
  input  logic [RATIO_W-1:0] cur_ratio,
  input  logic [VID_W-1:0]   cur_vid,
  input  logic               accept,
  output logic               job_valid,
  output logic [RATIO_W-1:0] job_ratio,
  output logic [VID_W-1:0]   job_vid,
  output logic               job_vid_first
);

  localparam logic [RATIO_W-1:0] LOW_R = RATIO_W'(LOW_RATIO);
  localparam logic [VID_W-1:0]   LOW_V = VID_W'(LOW_VID);

  logic               pend_wr_q, pend_wr_n;
  logic [RATIO_W-1:0] pend_ratio_q;
  logic [VID_W-1:0]   pend_vid_q;
  logic               pend_halt_q, pend_halt_n;
  logic               pend_enter_q, pend_enter_n;
  logic               halted_q, halted_n;
  logic [RATIO_W-1:0] save_ratio_q;
  logic [VID_W-1:0]   save_vid_q;

  logic [RATIO_W-1:0] clamped;
  logic               take_halt, take_wr, save_en;
  logic               enter_only, exit_only;

  // job presented to the engine: idle-point moves take precedence
  always_comb begin
    clamped = (wr_ratio > max_ratio) ? max_ratio : wr_ratio;
    if (pend_halt_q) begin
      job_valid = 1'b1;
      if (pend_enter_q) begin
        job_ratio     = LOW_R;
        job_vid       = LOW_V;
        job_vid_first = 1'b0;
      end else begin
        job_ratio     = save_ratio_q;
        job_vid       = save_vid_q;
        job_vid_first = 1'b1;
      end
    end else begin
      job_valid     = pend_wr_q & ~halted_q;
      job_ratio     = pend_ratio_q;
      job_vid       = pend_vid_q;
      job_vid_first = (pend_ratio_q > cur_ratio);
    end
  end

  // next-state of the held requests
  always_comb begin
    take_halt  = accept & pend_halt_q;
    take_wr    = accept & ~pend_halt_q;
    save_en    = take_halt & pend_enter_q;
    enter_only = halt_enter & ~halt_exit;
    exit_only  = halt_exit & ~halt_enter;

    pend_halt_n  = pend_halt_q & ~take_halt;
    pend_enter_n = pend_enter_q;
    halted_n     = halted_q;
    pend_wr_n    = (pend_wr_q & ~take_wr) | wr_en;

    if (enter_only && !halted_q) begin
      halted_n     = 1'b1;
      pend_halt_n  = 1'b1;
      pend_enter_n = 1'b1;
    end
    if (exit_only && halted_q) begin
      halted_n = 1'b0;
      if (pend_halt_n && pend_enter_q) begin
        pend_halt_n = 1'b0;
      end else begin
        pend_halt_n  = 1'b1;
        pend_enter_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr_q    <= 1'b0;
      pend_halt_q  <= 1'b0;
      pend_enter_q <= 1'b0;
      halted_q     <= 1'b0;
    end else begin
      pend_wr_q    <= pend_wr_n;
      pend_halt_q  <= pend_halt_n;
      pend_enter_q <= pend_enter_n;
      halted_q     <= halted_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ratio_q <= '0;
      pend_vid_q   <= '0;
    end else if (wr_en) begin
      pend_ratio_q <= clamped;
      pend_vid_q   <= wr_vid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_ratio_q <= '0;
      save_vid_q   <= '0;
    end else if (save_en) begin
      save_ratio_q <= cur_ratio;
      save_vid_q   <= cur_vid;
    end
  end

endmodule

// File: rtl/vfs_step_engine.sv
module vfs_step_engine
  import vfs_pkg::*;
#(
  parameter int RATIO_W     = 6,
  parameter int VID_W       = 7,
  parameter int SETTLE_W    = 8,
  parameter int RESET_RATIO = 8,
  parameter int RESET_VID   = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                job_valid,
  input  logic [RATIO_W-1:0]  job_ratio,
  input  logic [VID_W-1:0]    job_vid,
  input  logic                job_vid_first,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                accept,
  output logic [RATIO_W-1:0]  core_ratio,
  output logic [VID_W-1:0]    core_vid,
  output logic                busy,
  output logic                done
);

  seq_state_e         state_q, state_n;
  logic [RATIO_W-1:0] tgt_ratio_q;
  logic [VID_W-1:0]   tgt_vid_q;
  logic               vfirst_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [VID_W-1:0]   vid_q;

  logic tgt_en, ratio_en, vid_en, vid_up, timer_load, timer_last;

  vfs_settle_timer #(.SETTLE_W(SETTLE_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (timer_load),
    .value (settle_cycles),
    .last  (timer_last)
  );

  always_comb begin
    state_n    = state_q;
    accept     = 1'b0;
    tgt_en     = 1'b0;
    ratio_en   = 1'b0;
    vid_en     = 1'b0;
    vid_up     = 1'b0;
    timer_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (job_valid) begin
          accept  = 1'b1;
          tgt_en  = 1'b1;
          state_n = job_vid_first ? ST_VSTEP : ST_RATIO;
        end
      end
      ST_RATIO: begin
        ratio_en = 1'b1;
        state_n  = vfirst_q ? ST_FIN : ST_VSTEP;
      end
      ST_VSTEP: begin
        if (vid_q == tgt_vid_q) begin
          state_n = vfirst_q ? ST_RATIO : ST_FIN;
        end else begin
          vid_en = 1'b1;
          vid_up = (tgt_vid_q > vid_q);
          if (settle_cycles == '0) begin
            state_n = ST_VSTEP;
          end else begin
            timer_load = 1'b1;
            state_n    = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (timer_last) state_n = ST_VSTEP;
      end
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_ratio_q <= '0;
      tgt_vid_q   <= '0;
      vfirst_q    <= 1'b0;
    end else if (tgt_en) begin
      tgt_ratio_q <= job_ratio;
      tgt_vid_q   <= job_vid;
      vfirst_q    <= job_vid_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ratio_q <= RATIO_W'(RESET_RATIO);
    else if (ratio_en) ratio_q <= tgt_ratio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vid_q <= VID_W'(RESET_VID);
    else if (vid_en) vid_q <= vid_up ? (vid_q + VID_W'(1)) : (vid_q - VID_W'(1));
  end

  assign core_ratio = ratio_q;
  assign core_vid   = vid_q;
  assign busy       = (state_q == ST_RATIO) || (state_q == ST_VSTEP) || (state_q == ST_SETTLE);
  assign done       = (state_q == ST_FIN);

endmodule

// File: rtl/vf_sequencer.sv
module vf_sequencer #(
  parameter int RATIO_W     = 6,
  parameter int VID_W       = 7,
  parameter int SETTLE_W    = 8,
  parameter int RESET_RATIO = 8,
  parameter int RESET_VID   = 40,
  parameter int LOW_RATIO   = 6,
  parameter int LOW_VID     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RATIO_W-1:0]  wr_ratio,
  input  logic [VID_W-1:0]    wr_vid,
  input  logic [RATIO_W-1:0]  max_ratio,
  input  logic                halt_enter,
  input  logic                halt_exit,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [RATIO_W-1:0]  core_ratio,
  output logic [VID_W-1:0]    core_vid,
  output logic                busy,
  output logic                done
);

  logic               rst_meta_q, rst_sync_n;
  logic               accept, job_valid, job_vid_first;
  logic [RATIO_W-1:0] job_ratio;
  logic [VID_W-1:0]   job_vid;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  vfs_request_queue #(
    .RATIO_W   (RATIO_W),
    .VID_W     (VID_W),
    .LOW_RATIO (LOW_RATIO),
    .LOW_VID   (LOW_VID)
  ) i_queue (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (wr_en),
    .wr_ratio      (wr_ratio),
    .wr_vid        (wr_vid),
    .max_ratio     (max_ratio),
    .halt_enter    (halt_enter),
    .halt_exit     (halt_exit),
    .cur_ratio     (core_ratio),
    .cur_vid       (core_vid),
    .accept        (accept),
    .job_valid     (job_valid),
    .job_ratio     (job_ratio),
    .job_vid       (job_vid),
    .job_vid_first (job_vid_first)
  );

  vfs_step_engine #(
    .RATIO_W     (RATIO_W),
    .VID_W       (VID_W),
    .SETTLE_W    (SETTLE_W),
    .RESET_RATIO (RESET_RATIO),
    .RESET_VID   (RESET_VID)
  ) i_engine (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .job_valid     (job_valid),
    .job_ratio     (job_ratio),
    .job_vid       (job_vid),
    .job_vid_first (job_vid_first),
    .settle_cycles (settle_cycles),
    .accept        (accept),
    .core_ratio    (core_ratio),
    .core_vid      (core_vid),
    .busy          (busy),
    .done          (done)
  );

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 7,
  parameter int SETTLE_W  = 8,
  parameter int RESET_VID = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic [RATIO_W-1:0]  core_ratio,
  input logic [VID_W-1:0]    core_vid,
  input logic                busy,
  input logic                done,
  input logic [SETTLE_W-1:0] settle_cycles
);

  localparam int GAP_W = SETTLE_W + 1;

  logic [VID_W-1:0] prev_vid_q;
  logic [GAP_W-1:0] gap_q;
  logic             vid_chg;

  assign vid_chg = (core_vid != prev_vid_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vid_q <= VID_W'(RESET_VID);
      gap_q      <= '1;
    end else begin
      prev_vid_q <= core_vid;
      if (vid_chg)       gap_q <= GAP_W'(1);
      else if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R4: one code per change
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_vid) |->
      (core_vid == $past(core_vid) + VID_W'(1)) || (core_vid == $past(core_vid) - VID_W'(1)));

  // R4: settle spacing between changes
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    vid_chg |-> (gap_q >= ({1'b0, settle_cycles} + GAP_W'(1))));

  // R2: ratio and VID never move on the same edge
  a_r2_split_changes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_ratio) |-> $stable(core_vid));

  // R8: ratio moves only inside a sequence
  a_r8_ratio_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_ratio) |-> $past(busy));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: busy low while done
  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind vf_sequencer vfs_checker #(
  .RATIO_W   (RATIO_W),
  .VID_W     (VID_W),
  .SETTLE_W  (SETTLE_W),
  .RESET_VID (RESET_VID)
) i_vfs_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .core_ratio    (core_ratio),
  .core_vid      (core_vid),
  .busy          (busy),
  .done          (done),
  .settle_cycles (settle_cycles)
);

// File: tb/test_vf_sequencer.sv
module test_vf_sequencer;

  localparam int RATIO_W  = 6;
  localparam int VID_W    = 7;
  localparam int SETTLE_W = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                wr_en;
  logic [RATIO_W-1:0]  wr_ratio;
  logic [VID_W-1:0]    wr_vid;
  logic [RATIO_W-1:0]  max_ratio;
  logic                halt_enter;
  logic                halt_exit;
  logic [SETTLE_W-1:0] settle_cycles;
  logic [RATIO_W-1:0]  core_ratio;
  logic [VID_W-1:0]    core_vid;
  logic                busy;
  logic                done;

  int checks = 0;
  int errors = 0;

  // sequence statistics
  int s_busy, s_first_r, s_first_v, s_last_v, s_vchg, s_min_gap, s_maxstep, s_done;
  // quiet-window statistics
  int q_busy, q_done;

  always #5 clk = ~clk;

  vf_sequencer i_vf_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_ratio      (wr_ratio),
    .wr_vid        (wr_vid),
    .max_ratio     (max_ratio),
    .halt_enter    (halt_enter),
    .halt_exit     (halt_exit),
    .settle_cycles (settle_cycles),
    .core_ratio    (core_ratio),
    .core_vid      (core_vid),
    .busy          (busy),
    .done          (done)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_true(input string req, input string what, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_tgt(input int r, input int v);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_ratio = RATIO_W'(r);
    wr_vid   = VID_W'(v);
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic pulse(input bit ent, input bit ext);
    @(negedge clk);
    halt_enter = ent;
    halt_exit  = ext;
    @(negedge clk);
    halt_enter = 1'b0;
    halt_exit  = 1'b0;
  endtask

  task automatic run_seq(input string req);
    int pr;
    int pv;
    bit fin;
    pr = int'(core_ratio);
    pv = int'(core_vid);
    fin = 1'b0;
    s_busy = 0; s_first_r = -1; s_first_v = -1; s_last_v = -1;
    s_vchg = 0; s_min_gap = 1000000; s_maxstep = 0; s_done = 0;
    for (int i = 1; i <= 5000 && !fin; i++) begin
      @(negedge clk);
      if (busy) s_busy++;
      if (int'(core_ratio) != pr && s_first_r < 0) s_first_r = i;
      if (int'(core_vid) != pv) begin
        int d;
        d = int'(core_vid) - pv;
        if (d < 0) d = -d;
        if (d > s_maxstep) s_maxstep = d;
        if (s_last_v >= 0 && (i - s_last_v) < s_min_gap) s_min_gap = i - s_last_v;
        if (s_first_v < 0) s_first_v = i;
        s_last_v = i;
        s_vchg++;
      end
      pr = int'(core_ratio);
      pv = int'(core_vid);
      if (done) begin
        s_done++;
        fin = 1'b1;
      end
    end
    check_true(req, "sequence finished with done", fin, int'(fin), 1);
  endtask

  task automatic quiet(input int n);
    q_busy = 0;
    q_done = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) q_busy++;
      if (done) q_done++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "ratio in reset", int'(core_ratio), 8);
    check_eq("R1", "vid in reset", int'(core_vid), 40);
    rst_n = 1'b1;
    quiet(5);
    check_eq("R1", "busy after release", q_busy, 0);
    check_eq("R1", "done after release", q_done, 0);
    check_eq("R1", "ratio after release", int'(core_ratio), 8);
    check_eq("R1", "vid after release", int'(core_vid), 40);
  endtask

  task automatic t_raise;
    settle_cycles = 8'd4;
    max_ratio     = 6'd20;
    write_tgt(12, 43);
    run_seq("R2");
    check_eq("R2", "final ratio", int'(core_ratio), 12);
    check_eq("R2", "final vid", int'(core_vid), 43);
    check_true("R2", "last vid change before ratio change", s_last_v > 0 && s_first_r > s_last_v, s_first_r, s_last_v + 1);
    check_eq("R4", "vid step size", s_maxstep, 1);
    check_eq("R4", "vid step count", s_vchg, 3);
    check_eq("R4", "gap between steps", s_min_gap, 5);
    check_eq("R4", "busy cycles", s_busy, 17);
    quiet(10);
    check_eq("R12", "done count", s_done + q_done, 1);
  endtask

  task automatic t_lower;
    settle_cycles = 8'd2;
    write_tgt(9, 41);
    run_seq("R3");
    check_eq("R3", "final ratio", int'(core_ratio), 9);
    check_eq("R3", "final vid", int'(core_vid), 41);
    check_true("R3", "ratio change before first vid change", s_first_r > 0 && s_first_r < s_first_v, s_first_r, s_first_v - 1);
    check_eq("R4", "busy cycles lower", s_busy, 8);
  endtask

  task automatic t_clamp;
    max_ratio = 6'd10;
    write_tgt(30, 44);
    max_ratio = 6'd20;
    run_seq("R5");
    check_eq("R5", "clamped ratio", int'(core_ratio), 10);
    check_eq("R5", "vid", int'(core_vid), 44);
  endtask

  task automatic t_enter_hold_exit;
    settle_cycles = 8'd0;
    pulse(1'b1, 1'b0);
    run_seq("R6");
    check_eq("R6", "low ratio", int'(core_ratio), 6);
    check_eq("R6", "low vid", int'(core_vid), 32);
    check_true("R6", "ratio before vid", s_first_r > 0 && s_first_r < s_first_v, s_first_r, s_first_v - 1);
    check_eq("R6", "vid steps", s_vchg, 12);
    check_eq("R4", "gap with zero settle", s_min_gap, 1);
    write_tgt(14, 46);
    quiet(20);
    check_eq("R9", "no busy while idle point held", q_busy, 0);
    check_eq("R9", "ratio kept", int'(core_ratio), 6);
    pulse(1'b0, 1'b1);
    run_seq("R7");
    check_eq("R7", "restored ratio", int'(core_ratio), 10);
    check_eq("R7", "restored vid", int'(core_vid), 44);
    check_true("R7", "vid before ratio", s_last_v > 0 && s_first_r > s_last_v, s_first_r, s_last_v + 1);
    run_seq("R9");
    check_eq("R9", "held write ratio", int'(core_ratio), 14);
    check_eq("R9", "held write vid", int'(core_vid), 46);
  endtask

  task automatic t_ignored;
    pulse(1'b0, 1'b1);
    quiet(20);
    check_eq("R10", "exit outside idle point: busy", q_busy, 0);
    check_eq("R10", "exit outside idle point: ratio", int'(core_ratio), 14);
    pulse(1'b1, 1'b1);
    quiet(20);
    check_eq("R10", "both pulses: busy", q_busy, 0);
    check_eq("R10", "both pulses: vid", int'(core_vid), 46);
    pulse(1'b1, 1'b0);
    run_seq("R6");
    check_eq("R6", "second entry ratio", int'(core_ratio), 6);
    pulse(1'b1, 1'b0);
    quiet(20);
    check_eq("R10", "second enter: busy", q_busy, 0);
    check_eq("R10", "second enter: vid", int'(core_vid), 32);
    pulse(1'b0, 1'b1);
    run_seq("R7");
    check_eq("R7", "restore ratio again", int'(core_ratio), 14);
    check_eq("R7", "restore vid again", int'(core_vid), 46);
  endtask

  task automatic t_queue;
    settle_cycles = 8'd3;
    write_tgt(18, 48);
    fork
      run_seq("R8");
      begin
        repeat (3) @(negedge clk);
        write_tgt(16, 47);
        write_tgt(11, 44);
      end
    join
    check_eq("R8", "first point ratio", int'(core_ratio), 18);
    check_eq("R8", "first point vid", int'(core_vid), 48);
    run_seq("R8");
    check_eq("R8", "latest write ratio", int'(core_ratio), 11);
    check_eq("R8", "latest write vid", int'(core_vid), 44);
    quiet(20);
    check_eq("R12", "no extra done", q_done, 0);
  endtask

  task automatic t_cancel;
    write_tgt(15, 45);
    fork
      run_seq("R11");
      begin
        repeat (1) @(negedge clk);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
      end
    join
    quiet(30);
    check_eq("R11", "no sequence after cancel", q_busy, 0);
    check_eq("R11", "ratio unchanged", int'(core_ratio), 15);
    check_eq("R11", "vid unchanged", int'(core_vid), 45);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ratio = '0; wr_vid = '0;
    max_ratio = 6'd20; halt_enter = 1'b0; halt_exit = 1'b0; settle_cycles = 8'd4;
    t_reset();
    t_raise();
    t_lower();
    t_clamp();
    t_enter_hold_exit();
    t_ignored();
    t_queue();
    t_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule